// File: doc/BRIEF.md
# Wavelet Tree Level Interleaving Buffer

This block connects two levels of a wavelet-packet tree in which each level has one shared filter. The filter of the upstream level produces a beat of `LANES` samples on every valid cycle. The block collects those beats in a short fast shift register that moves one full beat per accepted cycle. Once two beats have been gathered, a registered transfer enable fires. It keeps half of the `2*LANES` samples, which performs the decimation by two, and pushes the resulting word into a slow shift register. Because transfers come at most every other cycle, the slow register moves at half the rate of the fast one.

The slow register is `2**LEVEL` words deep, so its length scales with the stage index. Words leave it in the order they were transferred. While beats arrive without gaps, each word stays on the output for two cycles. The flag `out_rep` marks the first (0) and second (1) cycle of each word, so the downstream merged filter can use it to select its low-pass and then its high-pass coefficients. A build-time mode chooses which half of each sample pair is kept. In one mode it is always the even-indexed samples. In the other, the choice alternates between even and odd on successive transfers, so kept approximation and detail samples alternate in the stream. The output stays zero and invalid until the slow register has been filled once after reset.

Top module: `wpt_level_interleaver`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `out_valid`, `out_rep` and `out_data` are all zero.
- R2: `out_valid` stays low, and `out_data` stays zero, until `2**LEVEL` transfers have completed. With beats arriving every cycle from the first clock edge after reset (edge 0), `out_valid` rises at edge `2*2**LEVEL` and then stays high.
- R3: One transfer happens for every second accepted beat, counting beats in pairs from reset. The transfer for beats 2n and 2n+1 takes effect on the clock edge after beat 2n+1 was accepted.
- R4: In even mode (`MODE = DECIM_EVEN`), lane j of transfer word n holds input sample number 2n·LANES + 2j. Input samples are numbered across beats, lane 0 first.
- R5: In alternating mode (`MODE = DECIM_ALTERNATE`), lane j of transfer word n holds input sample number 2n·LANES + 2j + (n mod 2).
- R6: Output words appear in transfer order. The first valid word is transfer word 0, and the word shown after transfer n is word n − 2**LEVEL + 1.
- R7: While input is continuous, each valid output word is held for exactly two cycles. `out_rep` is 0 in the first of those cycles and 1 in the second.
- R8: While `in_valid` is low, no transfer happens and `out_data` does not change. When beats resume, the next word shown is the one that follows in order.
- R9: Lane j of a word occupies bits `[j*SW +: SW]` on both `in_data` and `out_data`, and lane 0 carries the earliest sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A beat from the upstream filter is present |
| in_data | input | LANES*SW | Upstream beat, lane 0 earliest |
| out_valid | output | 1 | Slow register filled, output word valid |
| out_data | output | LANES*SW | Decimated interleaved word, zero while invalid |
| out_rep | output | 1 | 0 on the first cycle of a word, 1 on its repeat |

## Verification
A fast register that skips a beat, or a transfer enable that fires at the wrong parity, shows up on `out_data` within two cycles of the first valid word. The lane values then stop matching the ramp indices given by R4 and R5. A fill counter that is off by one moves the rising edge of `out_valid` by two cycles. A slow register that is too short or too long does the same, and it also shifts every later word. The bench runs a ramp through an even-mode instance and an alternating-mode instance at different levels and checks every cycle. It also holds off input in the middle of a stream, and it resets in the middle of a stream.

// File: rtl/wli_pkg.sv
`timescale 1ns/1ps
package wli_pkg;
   typedef enum logic {
      DECIM_EVEN      = 1'b0,
      DECIM_ALTERNATE = 1'b1
   } decim_mode_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/wli_fast_sreg.sv
`timescale 1ns/1ps
// Beat-rate shift register: advances one full word per accepted beat.
module wli_fast_sreg #(
   parameter int WW    = 64,
   parameter int DEPTH = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                shift_en,
   input  logic [WW-1:0]       din,
   output logic [DEPTH*WW-1:0] taps   // word 0 (oldest) in the low bits
);
   logic [WW-1:0] q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      end else if (shift_en) begin
         for (int i = 0; i < DEPTH - 1; i++) q[i] <= q[i+1];
         q[DEPTH-1] <= din;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_tap
      assign taps[g*WW +: WW] = q[g];
   end

   // the newest word tracks the beat that was accepted one edge earlier
   p_newest_loaded_r3: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (taps[(DEPTH-1)*WW +: WW] == $past(din)));
endmodule

// File: rtl/wli_decim.sv
`timescale 1ns/1ps
// Keeps one of every two samples of a gathered pair of beats.
module wli_decim #(
   parameter int LANES = 4,
   parameter int SW    = 16
) (
   input  logic [2*LANES*SW-1:0] pair,   // 2*LANES samples, sample 0 lowest
   input  logic                  odd_sel,
   output logic [LANES*SW-1:0]   word
);
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign word[j*SW +: SW] = odd_sel ? pair[(2*j+1)*SW +: SW]
                                        : pair[(2*j)*SW +: SW];
   end
endmodule

// File: rtl/wli_slow_sreg.sv
`timescale 1ns/1ps
// Transfer-rate shift register: one word per transfer, tail feeds the output.
module wli_slow_sreg #(
   parameter int WW    = 64,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          shift_en,
   input  logic [WW-1:0] din,
   output logic [WW-1:0] tail
);
   logic [WW-1:0] q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      end else if (shift_en) begin
         q[0] <= din;
         for (int i = 1; i < DEPTH; i++) q[i] <= q[i-1];
      end
   end

   assign tail = q[DEPTH-1];

   p_tail_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(tail));
endmodule

// File: rtl/wli_ctrl.sv
`timescale 1ns/1ps
// Per-level control: pairs beats, times transfers, tracks fill and parity.
module wli_ctrl import wli_pkg::*; #(
   parameter int          SLOW_WORDS = 4,
   parameter decim_mode_e MODE       = DECIM_EVEN
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   output logic xfer_en,
   output logic odd_sel,
   output logic filled
);
   localparam int CW = $clog2(SLOW_WORDS + 1);
   localparam logic [CW-1:0] FULL = CW'(SLOW_WORDS);

   logic          beat_ph;
   logic [CW-1:0] fill_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         beat_ph  <= 1'b0;
         xfer_en  <= 1'b0;
         fill_cnt <= '0;
      end else begin
         xfer_en <= in_valid & beat_ph;
         if (in_valid) beat_ph <= ~beat_ph;
         if (xfer_en && fill_cnt != FULL) fill_cnt <= fill_cnt + 1'b1;
      end
   end

   assign filled = (fill_cnt == FULL);

   if (MODE == DECIM_ALTERNATE) begin : g_alt
      logic par;
      always_ff @(posedge clk) begin
         if (rst)          par <= 1'b0;
         else if (xfer_en) par <= ~par;
      end
      assign odd_sel = par;
   end else begin : g_even
      assign odd_sel = 1'b0;
   end

   p_xfer_spacing_r3: assert property (@(posedge clk) disable iff (rst)
      xfer_en |=> !xfer_en);
   p_xfer_needs_beat_r3: assert property (@(posedge clk) disable iff (rst)
      xfer_en |-> $past(in_valid));
   p_fill_sticky_r2: assert property (@(posedge clk) disable iff (rst)
      filled |=> filled);
endmodule

// File: rtl/wpt_level_interleaver.sv
`timescale 1ns/1ps
module wpt_level_interleaver import wli_pkg::*; #(
   parameter int          LANES = 4,
   parameter int          SW    = 16,
   parameter int          LEVEL = 2,
   parameter decim_mode_e MODE  = DECIM_EVEN
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [LANES*SW-1:0] in_data,
   output logic                out_valid,
   output logic [LANES*SW-1:0] out_data,
   output logic                out_rep
);
   localparam int WORD_W     = LANES * SW;
   localparam int FAST_WORDS = 2;
   localparam int SLOW_WORDS = 1 << LEVEL;

   if (!is_pow2(LANES) || LANES < 2) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if (SW < 1) begin : g_bad_width
      $error("SW must be positive");
   end
   if (LEVEL < 1 || LEVEL > 10) begin : g_bad_level
      $error("LEVEL must lie in 1..10");
   end

   logic [FAST_WORDS*WORD_W-1:0] fast_taps;
   logic [WORD_W-1:0]            dec_word;
   logic [WORD_W-1:0]            slow_tail;
   logic                         xfer_en, odd_sel, filled;

   wli_ctrl #(.SLOW_WORDS(SLOW_WORDS), .MODE(MODE)) u_ctrl (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .xfer_en(xfer_en), .odd_sel(odd_sel), .filled(filled));

   wli_fast_sreg #(.WW(WORD_W), .DEPTH(FAST_WORDS)) u_fast (
      .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_data),
      .taps(fast_taps));

   wli_decim #(.LANES(LANES), .SW(SW)) u_decim (
      .pair(fast_taps), .odd_sel(odd_sel), .word(dec_word));

   wli_slow_sreg #(.WW(WORD_W), .DEPTH(SLOW_WORDS)) u_slow (
      .clk(clk), .rst(rst), .shift_en(xfer_en), .din(dec_word),
      .tail(slow_tail));

   always_ff @(posedge clk) begin
      if (rst)          out_rep <= 1'b0;
      else if (xfer_en) out_rep <= 1'b0;
      else if (filled)  out_rep <= ~out_rep;
   end

   assign out_valid = filled;
   assign out_data  = filled ? slow_tail : '0;

   p_valid_on_xfer_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(xfer_en));
   p_rep_zero_invalid_r7: assert property (@(posedge clk) disable iff (rst)
      !out_valid |=> !out_rep);
endmodule

// File: tb/wpt_level_interleaver_bench.sv
`timescale 1ns/1ps
module wpt_level_interleaver_bench;
   import wli_pkg::*;
   localparam int P  = 4;
   localparam int W  = 16;
   localparam int KA = 2;           // even-mode instance
   localparam int KB = 1;           // alternating-mode instance
   localparam int SA = 1 << KA;
   localparam int SB = 1 << KB;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           in_valid = 1'b0;
   logic [P*W-1:0] in_data = '0;
   logic           va, vb, ra, rb;
   logic [P*W-1:0] da, db;

   int total = 0;
   int bad   = 0;

   always #2ns clk = ~clk;

   wpt_level_interleaver #(.LANES(P), .SW(W), .LEVEL(KA), .MODE(DECIM_EVEN))
   u_wpt_level_interleaver (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(va), .out_data(da), .out_rep(ra));

   wpt_level_interleaver #(.LANES(P), .SW(W), .LEVEL(KB), .MODE(DECIM_ALTERNATE))
   u_wpt_level_interleaver_alt (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(vb), .out_data(db), .out_rep(rb));

   function automatic logic [P*W-1:0] ramp_beat(input int b);
      logic [P*W-1:0] r;
      for (int j = 0; j < P; j++) r[j*W +: W] = W'(b*P + j + 1);
      return r;
   endfunction

   function automatic logic [P*W-1:0] exp_word(input int n, input int off);
      logic [P*W-1:0] r;
      for (int j = 0; j < P; j++) r[j*W +: W] = W'(2*n*P + 2*j + off + 1);
      return r;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // c = number of clock edges since the one that took beat 0
   task automatic chk_inst(input string name, input int c, input int s, input bit alt,
                           input logic v, input logic [P*W-1:0] d, input logic r);
      int idx, n, off;
      idx = c - (2*s + 1);
      chk({"R2 valid ", name}, 64'(v), 64'(idx >= 0));
      if (idx < 0) begin
         chk({"R2 zero before fill ", name}, 64'(d), 64'd0);
      end else begin
         n   = idx / 2;
         off = alt ? (n % 2) : 0;
         chk(alt ? {"R5 R6 word ", name} : {"R4 R6 word ", name}, 64'(d), 64'(exp_word(n, off)));
         chk({"R7 repeat flag ", name}, 64'(r), 64'(idx % 2));
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; in_data = '0;
      @(negedge clk);
      @(negedge clk);
      chk("R1 valid in reset", 64'({va, vb}), 64'd0);
      chk("R1 data in reset",  64'(da | db),   64'd0);
      chk("R1 rep in reset",   64'({ra, rb}), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 outputs after release", 64'({va, vb, ra, rb}) | 64'(da | db), 64'd0);
   endtask

   task automatic t_stream(input int beats);
      do_reset();
      for (int b = 0; b < beats; b++) begin
         in_valid = 1'b1;
         in_data  = ramp_beat(b);
         @(negedge clk);
         chk_inst("even", b + 1, SA, 1'b0, va, da, ra);
         chk_inst("alt",  b + 1, SB, 1'b1, vb, db, rb);
      end
      in_valid = 1'b0;
      // lane 0 is the earliest kept sample (first word starts with sample 0)
      chk("R9 lane order", 64'(da[W-1:0]) < 64'(da[2*W-1:W]) ? 64'd1 : 64'd0, 64'd1);
   endtask

   task automatic t_stall();
      logic [P*W-1:0] held;
      int b;
      bit seen;
      do_reset();
      for (b = 0; b < 12; b++) begin
         in_valid = 1'b1;
         in_data  = ramp_beat(b);
         @(negedge clk);
      end
      in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      held = da;
      chk("R6 word before stall", 64'(held), 64'(exp_word(2, 0)));
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R8 data held in stall", 64'(da), 64'(held));
         chk("R8 valid held in stall", 64'(va), 64'd1);
      end
      seen = 1'b0;
      for (int i = 0; i < 10 && !seen; i++) begin
         in_valid = 1'b1;
         in_data  = ramp_beat(b);
         b++;
         @(negedge clk);
         if (da !== held) begin
            seen = 1'b1;
            chk("R8 next word after stall", 64'(da), 64'(exp_word(3, 0)));
         end
      end
      in_valid = 1'b0;
      chk("R8 output resumed", 64'(seen), 64'd1);
   endtask

   task automatic t_mid_reset();
      do_reset();
      for (int b = 0; b < 14; b++) begin
         in_valid = 1'b1;
         in_data  = ramp_beat(b);
         @(negedge clk);
      end
      chk("R2 valid before mid reset", 64'({va, vb}), 64'd3);
      do_reset();
      for (int b = 0; b < 6; b++) begin
         in_valid = 1'b1;
         in_data  = ramp_beat(b);
         @(negedge clk);
         chk_inst("even refill", b + 1, SA, 1'b0, va, da, ra);
      end
      in_valid = 1'b0;
   endtask

   initial begin
      #400000ns;
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_stream(40);
      t_stall();
      t_mid_reset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule